// File: doc/BRIEF.md
# Doorbell Request Responder

This block sits behind a packet parser on the receive side of a serial endpoint. It takes parsed request headers through a valid/ready stream and looks at each header's format type. Format type 10 marks a doorbell. The block answers every doorbell with a response header and, when the event is accepted, stores the requester's ID and the 16-bit info word in a small receive queue. Local logic drains that queue through a pop interface. Headers of any other format type go out unchanged on a bypass stream.

Acceptance is decided for each request on its own. If the queue has no free entry, the block discards the event and answers with a Retry status. It never stalls the link for lack of queue space. If the request is addressed to a different device ID, the block answers with an Error status. Only a pending response that the downstream side has not yet taken holds back new doorbells.

Top module: `doorbell_responder`

## Requirements
- R1: While reset is held, rsp_valid, q_valid and byp_valid are low. With a non-doorbell header (format type 0) at the input, req_ready follows byp_ready.
- R2: A request is a doorbell exactly when its format type field is 10. The 54-bit req_hdr is packed from MSB to LSB as follows:
  - transport type [53:52]
  - format type [51:48]
  - destination ID [47:40]
  - source ID [39:32]
  - reserved [31:24]
  - transaction ID [23:16]
  - info [15:0]
- R3: Each accepted doorbell yields one response in the cycle after acceptance. The 38-bit rsp_hdr is packed from MSB to LSB as follows:
  - transport type [37:36], copied from the request
  - format type [35:32] = 13
  - destination ID [31:24] = the request's source ID
  - source ID [23:16] = OWN_ID
  - transaction type [15:12] = 0000
  - status [11:8]
  - transaction ID [7:0], equal to the request's
- R4: If the destination ID equals OWN_ID and the queue holds fewer than DEPTH entries, the status is Done (0000) and the source ID and info are queued.
- R5: If the destination ID equals OWN_ID and the queue holds DEPTH entries, the status is Retry (0011) and the event is discarded.
- R6: If the destination ID differs from OWN_ID, the status is Error (0111) and nothing is queued, whatever the occupancy.
- R7: Occupancy is sampled before a pop. A doorbell accepted in the same cycle as a pop of a full queue is answered with Retry.
- R8: The queue is first-in first-out with DEPTH entries. q_valid is high while it holds an entry, and q_src and q_info show the oldest entry. A q_pop with q_valid high removes that entry.
- R9: The response holds stable while rsp_ready is low. req_ready stays low for a doorbell while a response is pending.
- R10: A non-doorbell header is presented on byp_hdr unchanged, with byp_valid high. req_ready for that header equals byp_ready. Such a header creates no response and no queue entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request header valid |
| req_ready | output | 1 | Request header accepted on this edge |
| req_hdr | input | 54 | Parsed request header |
| byp_valid | output | 1 | Non-doorbell header valid |
| byp_ready | input | 1 | Bypass consumer ready |
| byp_hdr | output | 54 | Non-doorbell header, unchanged |
| rsp_valid | output | 1 | Response header valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hdr | output | 38 | Response header |
| q_valid | output | 1 | Queue holds an event |
| q_pop | input | 1 | Remove the oldest event |
| q_src | output | 8 | Source ID of the oldest event |
| q_info | output | 16 | Info word of the oldest event |

## Verification
The assertions check the following on every cycle:
- the status chosen for each accepted doorbell against queue occupancy and address match;
- the transaction ID and requester ID echoed in the response;
- the occupancy bound;
- response stability under backpressure;
- doorbell blocking while a response is pending.

Only the bench's scenarios can show the rest:
- first-in first-out order and the content of queued events;
- that Retry and Error events are really absent once the queue is drained;
- the full-queue push with a same-cycle pop;
- exact pass-through of bypass headers.

// File: rtl/db_pkg.sv
package db_pkg;
  localparam int TT_W   = 2;
  localparam int FT_W   = 4;
  localparam int ID_W   = 8;
  localparam int TID_W  = 8;
  localparam int INFO_W = 16;
  localparam int ST_W   = 4;

  localparam logic [FT_W-1:0] FT_DOORBELL = 4'd10;
  localparam logic [FT_W-1:0] FT_RESPONSE = 4'd13;
  localparam logic [3:0]      TTYPE_PLAIN = 4'd0;

  typedef enum logic [ST_W-1:0] {
    ST_DONE  = 4'b0000,
    ST_RETRY = 4'b0011,
    ST_ERROR = 4'b0111
  } db_status_e;

  typedef struct packed {
    logic [TT_W-1:0]   tt;
    logic [FT_W-1:0]   ftype;
    logic [ID_W-1:0]   dst;
    logic [ID_W-1:0]   src;
    logic [7:0]        rsvd;
    logic [TID_W-1:0]  tid;
    logic [INFO_W-1:0] info;
  } db_req_t;

  typedef struct packed {
    logic [TT_W-1:0]  tt;
    logic [FT_W-1:0]  ftype;
    logic [ID_W-1:0]  dst;
    logic [ID_W-1:0]  src;
    logic [3:0]       ttype;
    logic [ST_W-1:0]  status;
    logic [TID_W-1:0] tid;
  } db_rsp_t;

  typedef struct packed {
    logic [ID_W-1:0]   src;
    logic [INFO_W-1:0] info;
  } db_event_t;

  localparam int REQ_W = $bits(db_req_t);
  localparam int RSP_W = $bits(db_rsp_t);
  localparam int EVT_W = $bits(db_event_t);

  // Address mismatch wins over a full queue.
  function automatic db_status_e pick_status(logic dst_ok, logic q_full);
    if (!dst_ok)     return ST_ERROR;
    else if (q_full) return ST_RETRY;
    else             return ST_DONE;
  endfunction

  function automatic db_rsp_t make_rsp(db_req_t r, logic [ID_W-1:0] own, db_status_e st);
    db_rsp_t o;
    o.tt     = r.tt;
    o.ftype  = FT_RESPONSE;
    o.dst    = r.src;
    o.src    = own;
    o.ttype  = TTYPE_PLAIN;
    o.status = st;
    o.tid    = r.tid;
    return o;
  endfunction
endpackage

// File: rtl/db_decode.sv
module db_decode
  import db_pkg::*;
#(
  parameter logic [ID_W-1:0] OWN_ID = 8'h5A
) (
  input  db_req_t req,
  output logic    is_db,
  output logic    dst_ok
);
  assign is_db  = (req.ftype == FT_DOORBELL);
  assign dst_ok = (req.dst == OWN_ID);
endmodule

// File: rtl/db_rsp_slot.sv
module db_rsp_slot
  import db_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  db_rsp_t load_data,
  input  logic    rsp_ready,
  output logic    rsp_valid,
  output db_rsp_t rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/db_event_fifo.sv
module db_event_fifo
  import db_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  db_event_t        din,
  input  logic             pop,
  output db_event_t        head,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);
  db_event_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/doorbell_responder.sv
module doorbell_responder
  import db_pkg::*;
#(
  parameter int              DEPTH  = 8,
  parameter logic [ID_W-1:0] OWN_ID = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REQ_W-1:0]  req_hdr,
  output logic              byp_valid,
  input  logic              byp_ready,
  output logic [REQ_W-1:0]  byp_hdr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [RSP_W-1:0]  rsp_hdr,
  output logic              q_valid,
  input  logic              q_pop,
  output logic [ID_W-1:0]   q_src,
  output logic [INFO_W-1:0] q_info
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  db_req_t          req_s;
  db_rsp_t          rsp_next, rsp_s;
  db_event_t        ev_in, ev_head;
  db_status_e       status;
  logic             is_db, dst_ok;
  logic             q_full, q_empty;
  logic [LVL_W-1:0] q_level;
  logic             db_fire, q_push;

  assign req_s = db_req_t'(req_hdr);

  db_decode #(.OWN_ID(OWN_ID)) u_decode (
    .req    (req_s),
    .is_db  (is_db),
    .dst_ok (dst_ok)
  );

  // Doorbells wait only on the response slot; other headers on the bypass.
  assign req_ready = is_db ? !rsp_valid : byp_ready;
  assign byp_valid = req_valid && !is_db;
  assign byp_hdr   = req_hdr;

  assign db_fire  = req_valid && req_ready && is_db;
  assign status   = pick_status(dst_ok, q_full);
  assign q_push   = db_fire && (status == ST_DONE);
  assign rsp_next = make_rsp(req_s, OWN_ID, status);
  assign ev_in    = '{src: req_s.src, info: req_s.info};

  db_rsp_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (db_fire),
    .load_data (rsp_next),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_s)
  );
  assign rsp_hdr = rsp_s;

  db_event_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (q_push),
    .din   (ev_in),
    .pop   (q_pop),
    .head  (ev_head),
    .full  (q_full),
    .empty (q_empty),
    .level (q_level)
  );

  assign q_valid = !q_empty;
  assign q_src   = ev_head.src;
  assign q_info  = ev_head.info;
endmodule

// File: rtl/db_checker.sv
module db_checker
  import db_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input db_req_t          req_s,
  input logic             is_db,
  input logic             dst_ok,
  input logic             q_full,
  input logic [LVL_W-1:0] q_level,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input db_rsp_t          rsp_s
);
  logic fire_db, fire_other;
  assign fire_db    = req_valid && req_ready && is_db;
  assign fire_other = req_valid && req_ready && !is_db;

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= LVL_W'(DEPTH));

  p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_db && dst_ok && !q_full) |=> (rsp_valid && rsp_s.status == ST_DONE));

  p_retry_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_db && dst_ok && q_full) |=>
      (rsp_s.status == ST_RETRY && q_level <= $past(q_level)));

  p_error_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_db && !dst_ok) |=>
      (rsp_s.status == ST_ERROR && q_level <= $past(q_level)));

  p_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_db |=> (rsp_s.tid == $past(req_s.tid) && rsp_s.dst == $past(req_s.src)
                 && rsp_s.ftype == FT_RESPONSE));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_s)));

  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && req_valid && is_db) |-> !req_ready);

  p_bypass_noq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire_other |=> (q_level <= $past(q_level)));
endmodule

bind doorbell_responder db_checker #(.DEPTH(DEPTH)) u_db_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_s     (req_s),
  .is_db     (is_db),
  .dst_ok    (dst_ok),
  .q_full    (q_full),
  .q_level   (q_level),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_s     (rsp_s)
);

// File: tb/test_doorbell_responder.sv
module test_doorbell_responder;
  localparam int         CLK_PERIOD = 10;
  localparam int         DEPTH      = 8;
  localparam logic [7:0] OWN        = 8'h5A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [53:0] req_hdr = '0;
  logic        byp_valid;
  logic        byp_ready = 1'b1;
  logic [53:0] byp_hdr;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [37:0] rsp_hdr;
  logic        q_valid;
  logic        q_pop = 1'b0;
  logic [7:0]  q_src;
  logic [15:0] q_info;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  int model_level = 0;

  logic [37:0] exp_rsp[$];
  logic [53:0] exp_byp[$];
  logic [23:0] exp_ev[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  doorbell_responder #(.DEPTH(DEPTH), .OWN_ID(OWN)) i_doorbell_responder (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_hdr(req_hdr),
    .byp_valid(byp_valid), .byp_ready(byp_ready), .byp_hdr(byp_hdr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hdr(rsp_hdr),
    .q_valid(q_valid), .q_pop(q_pop), .q_src(q_src), .q_info(q_info)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [53:0] req_word(logic [1:0] tt, logic [3:0] ft, logic [7:0] dst,
                                           logic [7:0] src, logic [7:0] tid, logic [15:0] info);
    return {tt, ft, dst, src, 8'h00, tid, info};
  endfunction

  // Expected response built field by field from R3, status from R4/R5/R6.
  function automatic logic [37:0] rsp_word(logic [1:0] tt, logic [7:0] req_src,
                                           logic [3:0] st, logic [7:0] tid);
    return {tt, 4'd13, req_src, OWN, 4'b0000, st, tid};
  endfunction

  // Scoreboard entry for one doorbell, using the bench's own occupancy model.
  task automatic expect_db(logic [1:0] tt, logic [7:0] dst, logic [7:0] src,
                           logic [7:0] tid, logic [15:0] info);
    logic [3:0] st;
    if (dst != OWN)                st = 4'b0111;
    else if (model_level >= DEPTH) st = 4'b0011;
    else                           st = 4'b0000;
    if (st == 4'b0000) begin
      exp_ev.push_back({src, info});
      model_level++;
    end
    exp_rsp.push_back(rsp_word(tt, src, st, tid));
  endtask

  task automatic drive(logic [53:0] w);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_hdr   = w;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic send_db(logic [1:0] tt, logic [7:0] dst, logic [7:0] src,
                         logic [7:0] tid, logic [15:0] info);
    expect_db(tt, dst, src, tid, info);
    drive(req_word(tt, 4'd10, dst, src, tid, info));
  endtask

  task automatic pop_check(string tag);
    @(negedge clk);
    check(q_valid == 1'b1, {tag, " q_valid"}, q_valid, 1);
    check({q_src, q_info} == exp_ev[0], {tag, " head"}, {q_src, q_info}, exp_ev[0]);
    @(posedge clk); #1;
    q_pop = 1'b1;
    @(posedge clk); #1;
    q_pop = 1'b0;
    void'(exp_ev.pop_front());
    model_level--;
  endtask

  // Monitor: responses and bypass headers compared where the handshake completes.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_rsp.size() == 0) check(1'b0, "R10 unexpected response", rsp_hdr, 0);
      else begin
        logic [37:0] e;
        e = exp_rsp.pop_front();
        case (e[11:8])
          4'b0000: check(rsp_hdr == e, "R3/R4 response Done", rsp_hdr, e);
          4'b0011: check(rsp_hdr == e, "R3/R5 response Retry", rsp_hdr, e);
          default: check(rsp_hdr == e, "R3/R6 response Error", rsp_hdr, e);
        endcase
      end
    end
    if (rst_n && byp_valid && byp_ready) begin
      if (exp_byp.size() == 0) check(1'b0, "R2 unexpected bypass", byp_hdr, 0);
      else begin
        logic [53:0] b;
        b = exp_byp.pop_front();
        check(byp_hdr == b, "R10 bypass header", byp_hdr, b);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 0, "R1 rsp_valid in reset", rsp_valid, 0);
    check(q_valid == 0, "R1 q_valid in reset", q_valid, 0);
    check(byp_valid == 0, "R1 byp_valid in reset", byp_valid, 0);
    check(req_ready == 1, "R1 req_ready follows byp_ready", req_ready, 1);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R4/R8: several accepted doorbells, drained in order
    send_db(2'b01, OWN, 8'h11, 8'hA0, 16'h1234);
    send_db(2'b00, OWN, 8'h22, 8'hA1, 16'hBEEF);
    send_db(2'b10, OWN, 8'h33, 8'hFF, 16'h0001);
    pop_check("R8 first");
    pop_check("R8 second");
    pop_check("R8 third");
    @(negedge clk);
    check(q_valid == 0, "R8 drained", q_valid, 0);

    // R6: wrong destination gives Error and queues nothing
    send_db(2'b01, 8'h5B, 8'h44, 8'h07, 16'hCAFE);
    @(negedge clk);
    check(q_valid == 0, "R6 error not queued", q_valid, 0);

    // R5: fill, then Retry; R6 precedence while full
    for (int i = 0; i < DEPTH; i++)
      send_db(2'b01, OWN, 8'(8'h60 + i), 8'(i), 16'(16'h1000 + i));
    send_db(2'b01, OWN, 8'h77, 8'h90, 16'hDEAD);
    send_db(2'b01, 8'h00, 8'h78, 8'h91, 16'hDEAD);

    // R7: doorbell and pop in the same cycle on a full queue -> Retry
    exp_rsp.push_back(rsp_word(2'b11, 8'h79, 4'b0011, 8'h92));
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_hdr   = req_word(2'b11, 4'd10, OWN, 8'h79, 8'h92, 16'h5555);
    q_pop     = 1'b1;
    @(negedge clk);
    check(req_ready == 1, "R7 doorbell accepted with pop", req_ready, 1);
    check({q_src, q_info} == exp_ev[0], "R7 popped head", {q_src, q_info}, exp_ev[0]);
    @(posedge clk); #1;
    req_valid = 1'b0;
    q_pop     = 1'b0;
    void'(exp_ev.pop_front());
    model_level--;

    // the freed slot takes the next doorbell
    send_db(2'b00, OWN, 8'h7A, 8'h93, 16'h4242);
    for (int i = 0; i < DEPTH; i++) pop_check("R5/R8 drain");
    @(negedge clk);
    check(q_valid == 0, "R5 retried events absent", q_valid, 0);

    // R9: backpressure holds the response and blocks the next doorbell
    @(posedge clk); #1;
    rsp_ready = 1'b0;
    send_db(2'b01, OWN, 8'h81, 8'hC1, 16'h0A0A);
    expect_db(2'b10, OWN, 8'h82, 8'hC2, 16'h0B0B);
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_hdr   = req_word(2'b10, 4'd10, OWN, 8'h82, 8'hC2, 16'h0B0B);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(req_ready == 0, "R9 doorbell blocked", req_ready, 0);
      check(rsp_valid == 1 && rsp_hdr == exp_rsp[0], "R9 response held", rsp_hdr, exp_rsp[0]);
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    pop_check("R9 first");
    pop_check("R9 second");

    // R10/R2: non-doorbell headers bypass
    @(posedge clk); #1;
    byp_ready = 1'b0;
    exp_byp.push_back(req_word(2'b01, 4'd11, OWN, 8'h91, 8'hD1, 16'h7777));
    req_valid = 1'b1;
    req_hdr   = exp_byp[0];
    @(negedge clk);
    check(req_ready == 0, "R10 ready follows byp_ready", req_ready, 0);
    check(byp_valid == 1, "R2 format 11 is not a doorbell", byp_valid, 1);
    @(posedge clk); #1;
    byp_ready = 1'b1;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    exp_byp.push_back(req_word(2'b11, 4'd13, 8'h12, 8'h34, 8'h56, 16'h789A));
    drive(exp_byp[exp_byp.size()-1]);
    @(negedge clk);
    check(q_valid == 0, "R10 bypass not queued", q_valid, 0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(exp_rsp.size() == 0, "R3 all responses seen", exp_rsp.size(), 0);
    check(exp_byp.size() == 0, "R10 all bypass seen", exp_byp.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule